// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation-cache miss. It walks a two-level table kept in word-organised memory. A walk begins when the requester hands over the virtual address, the kind of access (read, write or instruction fetch) and the base of the root table. The walker then reads the directory entry, and after that the table entry that the directory entry points to. It returns either the physical address together with the effective write permission or a fault, and it reports the level at which the fault was found.

Every memory access goes through one valid/ready port. Read data comes back on a separate valid strobe, after a latency the walker does not control. The walker accepts one walk at a time and does not take a new request until the requester has accepted the response. When a walk uses an entry whose accessed flag is clear, or writes to a page whose dirty flag is clear, the walker writes the updated entry back to memory before it moves on.

Top module: `pgw_walker`

## Requirements
- R1: Out of reset, req_ready is 1, and rsp_valid and mem_valid are 0.
- R2: The first memory access of a walk is a read of the directory entry. Its byte address is the root frame (root bits 31..12) followed by virtual bits 31..22 and two zero bits.
- R3: The table entry is read only after a present directory entry has been returned. Its byte address is the directory entry's bits 31..12 followed by virtual bits 21..12 and two zero bits.
- R4: A walk without a fault returns rsp_fault=0 and an rsp_paddr made of table-entry bits 31..12 followed by virtual bits 11..0.
- R5: A directory entry with bit 0 (present) clear ends the walk with rsp_fault=1 and rsp_fault_lvl=0. No table read and no write-back take place.
- R6: A table entry with present clear ends the walk with rsp_fault=1 and rsp_fault_lvl=1. It causes no write-back.
- R7: req_kind codes are 0 read, 1 write and 2 fetch. A write faults when bit 1 (writable) is clear in the directory entry (rsp_fault_lvl=0) or in the table entry (rsp_fault_lvl=1). Reads and fetches of non-writable pages succeed. rsp_writable is the AND of both writable bits.
- R8: When a walk uses an entry whose bit 5 (accessed) is clear, the walker writes that entry back with bit 5 set. The directory entry is written back before the table read.
- R9: A write access whose table entry has bit 6 (dirty) clear writes the table entry back with bit 6 set. Reads and fetches never set bit 6, and the dirty bit is never set in a directory entry.
- R10: An entry whose needed status bits are already set is not written back. A faulting level is never written back.
- R11: From acceptance until the response handshake, req_ready stays 0. While rsp_valid=1 and rsp_ready=0, the response outputs hold their values.
- R12: While mem_valid=1 and mem_ready=0, the address, the write flag and the write data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_root | input | 32 | Root table base (bits 31..12 used) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_fault_lvl | output | 1 | Fault level: 0 directory, 1 table |
| rsp_writable | output | 1 | Effective write permission of the page |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory takes the access |
| mem_write | output | 1 | 1 write-back, 0 read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench aims at the status-bit write-back rules. It runs a first touch that needs both levels updated, a write to a page that is already accessed but clean, and repeated walks that must cause no memory writes. A walker that wrote back unconditionally, or set the dirty bit on reads, would show up as extra write handshakes or wrong memory contents. Faults are raised at each level, with no table read after a bad directory entry, so a walker that read ahead or wrote status into a faulting entry would change the access log. The bench also uses the extreme indices and offsets, a stalled memory port and a stalled response, which catch address slicing mistakes and outputs that drift during a stall.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } pgw_kind_e;

   typedef enum logic [3:0] {
      S_IDLE     = 4'd0,
      S_DIR_RD   = 4'd1,
      S_DIR_WAIT = 4'd2,
      S_DIR_EVAL = 4'd3,
      S_DIR_WB   = 4'd4,
      S_TBL_RD   = 4'd5,
      S_TBL_WAIT = 4'd6,
      S_TBL_EVAL = 4'd7,
      S_TBL_WB   = 4'd8,
      S_RESP     = 4'd9
   } pgw_state_e;

   localparam int unsigned PGW_LEVELS = 2;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 32,
   parameter int unsigned OFFS_W  = 12,
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned ENT_LG2 = 2
) (
   input  logic [VA_W-1:0]        vaddr,
   input  logic [PA_W-OFFS_W-1:0] root_frame,
   input  logic [PA_W-OFFS_W-1:0] dir_frame,
   input  logic [PA_W-OFFS_W-1:0] pte_frame,
   output logic [PA_W-1:0]        dir_addr,
   output logic [PA_W-1:0]        tbl_addr,
   output logic [PA_W-1:0]        paddr
);
   localparam int unsigned HI_LSB = OFFS_W + IDX_W;

   if (VA_W != OFFS_W + 2 * IDX_W) begin : g_bad_split
      $error("pgw_addr_gen: VA_W must equal OFFS_W + 2*IDX_W");
   end
   if (OFFS_W != IDX_W + ENT_LG2) begin : g_bad_scale
      $error("pgw_addr_gen: a scaled index must fill one page");
   end

   always_comb begin
      dir_addr = {root_frame, vaddr[VA_W-1:HI_LSB], {ENT_LG2{1'b0}}};
      tbl_addr = {dir_frame, vaddr[HI_LSB-1:OFFS_W], {ENT_LG2{1'b0}}};
      paddr    = {pte_frame, vaddr[OFFS_W-1:0]};
   end
endmodule

// File: rtl/pgw_perm_chk.sv
module pgw_perm_chk
   import pgw_pkg::*;
#(
   parameter int unsigned ENT_W    = 32,
   parameter int unsigned PRES_BIT = 0,
   parameter int unsigned WR_BIT   = 1,
   parameter int unsigned ACC_BIT  = 5,
   parameter int unsigned DRTY_BIT = 6,
   parameter bit          LEAF     = 1'b1,
   parameter bit          CHECK_WR = 1'b1
) (
   input  logic [ENT_W-1:0] entry,
   input  pgw_kind_e        kind,
   output logic             fault,
   output logic             need_wb,
   output logic [ENT_W-1:0] wb_data
);
   localparam logic [ENT_W-1:0] ACC_MASK  = ENT_W'(1) << ACC_BIT;
   localparam logic [ENT_W-1:0] DRTY_MASK = ENT_W'(1) << DRTY_BIT;

   if (PRES_BIT >= ENT_W || WR_BIT >= ENT_W || ACC_BIT >= ENT_W || DRTY_BIT >= ENT_W) begin : g_bad_bits
      $error("pgw_perm_chk: flag bit outside entry");
   end

   logic wr_denied;
   logic [ENT_W-1:0] set_mask;

   if (CHECK_WR) begin : g_wr_chk
      assign wr_denied = (kind == ACC_WRITE) && !entry[WR_BIT];
   end else begin : g_wr_free
      assign wr_denied = 1'b0;
   end

   if (LEAF) begin : g_leaf
      assign set_mask = (kind == ACC_WRITE) ? (ACC_MASK | DRTY_MASK) : ACC_MASK;
   end else begin : g_node
      assign set_mask = ACC_MASK;
   end

   always_comb begin
      fault   = !entry[PRES_BIT] || wr_denied;
      wb_data = entry | set_mask;
      need_wb = !fault && (wb_data != entry);
   end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       mem_ready,
   input  logic       mem_rvalid,
   input  logic       dir_fault,
   input  logic       dir_wb,
   input  logic       tbl_fault,
   input  logic       tbl_wb,
   input  logic       rsp_ready,
   output pgw_state_e state_q
);
   pgw_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:     if (req_valid)  state_d = S_DIR_RD;
         S_DIR_RD:   if (mem_ready)  state_d = S_DIR_WAIT;
         S_DIR_WAIT: if (mem_rvalid) state_d = S_DIR_EVAL;
         S_DIR_EVAL: begin
            if (dir_fault)   state_d = S_RESP;
            else if (dir_wb) state_d = S_DIR_WB;
            else             state_d = S_TBL_RD;
         end
         S_DIR_WB:   if (mem_ready)  state_d = S_TBL_RD;
         S_TBL_RD:   if (mem_ready)  state_d = S_TBL_WAIT;
         S_TBL_WAIT: if (mem_rvalid) state_d = S_TBL_EVAL;
         S_TBL_EVAL: begin
            if (!tbl_fault && tbl_wb) state_d = S_TBL_WB;
            else                      state_d = S_RESP;
         end
         S_TBL_WB:   if (mem_ready)  state_d = S_RESP;
         S_RESP:     if (rsp_ready)  state_d = S_IDLE;
         default:                    state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end

   assert_legal_state_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RESP && !rsp_ready) |=> (state_q == S_RESP));
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned PA_W     = 32,
   parameter int unsigned OFFS_W   = 12,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned ENT_LG2  = 2,
   parameter int unsigned PRES_BIT = 0,
   parameter int unsigned WR_BIT   = 1,
   parameter int unsigned ACC_BIT  = 5,
   parameter int unsigned DRTY_BIT = 6,
   parameter bit          STRICT_DIR_WR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_kind,
   input  logic [PA_W-1:0] req_root,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_fault,
   output logic            rsp_fault_lvl,
   output logic            rsp_writable,
   output logic            mem_valid,
   input  logic            mem_ready,
   output logic            mem_write,
   output logic [PA_W-1:0] mem_addr,
   output logic [PA_W-1:0] mem_wdata,
   input  logic            mem_rvalid,
   input  logic [PA_W-1:0] mem_rdata
);
   localparam int unsigned FRAME_W = PA_W - OFFS_W;
   localparam int unsigned NLVL    = PGW_LEVELS;

   if (PA_W < OFFS_W + 1) begin : g_bad_pa
      $error("pgw_walker: physical width too small");
   end

   pgw_state_e              state_q;
   logic [VA_W-1:0]         vaddr_q;
   logic [FRAME_W-1:0]      root_q;
   pgw_kind_e               kind_q;
   logic [NLVL-1:0][PA_W-1:0] ent_q;
   logic                    fault_q;
   logic                    flvl_q;

   logic [NLVL-1:0]           lvl_fault;
   logic [NLVL-1:0]           lvl_wb;
   logic [NLVL-1:0][PA_W-1:0] lvl_wbdata;
   logic [PA_W-1:0]           dir_addr, tbl_addr, paddr;
   logic                      dir_wr_ok;

   // one permission checker per table level
   for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
      pgw_perm_chk #(
         .ENT_W    (PA_W),
         .PRES_BIT (PRES_BIT),
         .WR_BIT   (WR_BIT),
         .ACC_BIT  (ACC_BIT),
         .DRTY_BIT (DRTY_BIT),
         .LEAF     (lv == NLVL - 1),
         .CHECK_WR ((lv == NLVL - 1) ? 1'b1 : STRICT_DIR_WR)
      ) i_chk (
         .entry   (ent_q[lv]),
         .kind    (kind_q),
         .fault   (lvl_fault[lv]),
         .need_wb (lvl_wb[lv]),
         .wb_data (lvl_wbdata[lv])
      );
   end

   pgw_addr_gen #(
      .VA_W    (VA_W),
      .PA_W    (PA_W),
      .OFFS_W  (OFFS_W),
      .IDX_W   (IDX_W),
      .ENT_LG2 (ENT_LG2)
   ) i_addr (
      .vaddr      (vaddr_q),
      .root_frame (root_q),
      .dir_frame  (ent_q[0][PA_W-1:OFFS_W]),
      .pte_frame  (ent_q[1][PA_W-1:OFFS_W]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .paddr      (paddr)
   );

   pgw_ctrl i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .dir_fault  (lvl_fault[0]),
      .dir_wb     (lvl_wb[0]),
      .tbl_fault  (lvl_fault[1]),
      .tbl_wb     (lvl_wb[1]),
      .rsp_ready  (rsp_ready),
      .state_q    (state_q)
   );

   // walk context and fetched entries
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vaddr_q <= '0;
         root_q  <= '0;
         kind_q  <= ACC_READ;
         ent_q   <= '0;
         fault_q <= 1'b0;
         flvl_q  <= 1'b0;
      end else begin
         if (state_q == S_IDLE && req_valid) begin
            vaddr_q <= req_vaddr;
            root_q  <= req_root[PA_W-1:OFFS_W];
            kind_q  <= pgw_kind_e'(req_kind);
            fault_q <= 1'b0;
            flvl_q  <= 1'b0;
         end
         if (state_q == S_DIR_WAIT && mem_rvalid) ent_q[0] <= mem_rdata;
         if (state_q == S_TBL_WAIT && mem_rvalid) ent_q[1] <= mem_rdata;
         if (state_q == S_DIR_EVAL && lvl_fault[0]) begin
            fault_q <= 1'b1;
            flvl_q  <= 1'b0;
         end
         if (state_q == S_TBL_EVAL && lvl_fault[1]) begin
            fault_q <= 1'b1;
            flvl_q  <= 1'b1;
         end
      end
   end

   if (STRICT_DIR_WR) begin : g_dir_wr
      assign dir_wr_ok = ent_q[0][WR_BIT];
   end else begin : g_dir_free
      assign dir_wr_ok = 1'b1;
   end

   // memory port and response decode
   always_comb begin
      req_ready     = (state_q == S_IDLE);
      rsp_valid     = (state_q == S_RESP);
      rsp_fault     = fault_q;
      rsp_fault_lvl = flvl_q;
      rsp_paddr     = fault_q ? '0 : paddr;
      rsp_writable  = !fault_q && dir_wr_ok && ent_q[1][WR_BIT];
      mem_valid     = 1'b0;
      mem_write     = 1'b0;
      mem_addr      = '0;
      mem_wdata     = '0;
      unique case (state_q)
         S_DIR_RD: begin
            mem_valid = 1'b1;
            mem_addr  = dir_addr;
         end
         S_DIR_WB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = dir_addr;
            mem_wdata = lvl_wbdata[0];
         end
         S_TBL_RD: begin
            mem_valid = 1'b1;
            mem_addr  = tbl_addr;
         end
         S_TBL_WB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = lvl_wbdata[1];
         end
         default: ;
      endcase
   end

   assert_rsp_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                     && $stable(rsp_fault_lvl) && $stable(rsp_writable)));

   assert_one_walk_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_mem_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                     && $stable(mem_wdata)));

   assert_wb_acc_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> mem_wdata[ACC_BIT]);

   assert_dirty_on_write_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && mem_wdata[DRTY_BIT] && !ent_q[1][DRTY_BIT]
       && state_q == S_TBL_WB) |-> (kind_q == ACC_WRITE));

   assert_tbl_after_dir_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_write && state_q == S_TBL_RD) |-> ent_q[0][PRES_BIT]);

   assert_no_wb_on_fault_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> !mem_valid);
endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic [31:0] req_root = '0;
   logic        rsp_valid, rsp_ready;
   logic [31:0] rsp_paddr;
   logic        rsp_fault, rsp_fault_lvl, rsp_writable;
   logic        mem_valid, mem_write;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   pgw_walker i_pgw_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_root(req_root),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .rsp_writable(rsp_writable),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // memory model: 16 KiB, variable ready and read latency
   bit [31:0] mem [0:4095];
   logic [7:0]  cyc = '0;
   logic        rdy_q = 1'b0;
   logic        pend = 1'b0;
   logic [1:0]  dly = '0;
   logic [11:0] pidx = '0;
   int          rd_total = 0, wr_total = 0, range_bad = 0;
   logic [31:0] rd_log [0:15];
   logic [31:0] wr_log [0:15];
   assign mem_ready = rdy_q;

   always @(posedge clk) begin
      cyc <= cyc + 8'd1;
      rdy_q <= (cyc[1:0] != 2'd2);
      mem_rvalid <= 1'b0;
      if (pend) begin
         if (dly == 2'd0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[pidx];
            pend       <= 1'b0;
         end else dly <= dly - 2'd1;
      end
      if (mem_valid && rdy_q) begin
         if (mem_addr[31:14] != 18'd0) range_bad <= range_bad + 1;
         if (mem_write) begin
            mem[mem_addr[13:2]]  <= mem_wdata;
            wr_log[wr_total % 16] <= mem_addr;
            wr_total <= wr_total + 1;
         end else begin
            pend <= 1'b1;
            dly  <= cyc[2:1];
            pidx <= mem_addr[13:2];
            rd_log[rd_total % 16] <= mem_addr;
            rd_total <= rd_total + 1;
         end
      end
   end

   // response backpressure
   int stall_len = 0;
   int stall_left = 0;
   assign rsp_ready = (stall_left == 0);
   always @(posedge clk) begin
      if (req_valid && req_ready) stall_left <= stall_len;
      else if (rsp_valid && stall_left != 0) stall_left <= stall_left - 1;
   end

   // scoreboard
   typedef struct {
      logic        fault;
      logic        lvl;
      logic [31:0] pa;
      logic        wr;
      string       req;
   } exp_t;
   exp_t exp_q[$];
   int done_cnt = 0;
   int hold_bad = 0;
   logic        prev_mstall = 1'b0, prev_rstall = 1'b0;
   logic [31:0] prev_maddr = '0, prev_mwdata = '0, prev_rpa = '0;
   logic        prev_mwr = 1'b0, prev_rfault = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_mstall && !(mem_valid && mem_addr == prev_maddr && mem_write == prev_mwr
                              && mem_wdata == prev_mwdata)) hold_bad++;
         if (prev_rstall) begin
            chk(rsp_valid && rsp_paddr == prev_rpa && rsp_fault == prev_rfault,
                "R11", "response held during stall", rsp_paddr, prev_rpa);
         end
         if (rsp_valid && !rsp_ready)
            chk(!req_ready, "R11", "req_ready low while busy", 32'(req_ready), 32'd0);
         if (rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected response", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(rsp_fault == e.fault, e.req, "rsp_fault", 32'(rsp_fault), 32'(e.fault));
               if (e.fault)
                  chk(rsp_fault_lvl == e.lvl, e.req, "rsp_fault_lvl", 32'(rsp_fault_lvl), 32'(e.lvl));
               else begin
                  chk(rsp_paddr == e.pa, e.req, "rsp_paddr", rsp_paddr, e.pa);
                  chk(rsp_writable == e.wr, e.req, "rsp_writable", 32'(rsp_writable), 32'(e.wr));
               end
            end
            done_cnt++;
         end
         prev_mstall = mem_valid && !mem_ready;
         prev_maddr  = mem_addr;
         prev_mwr    = mem_write;
         prev_mwdata = mem_wdata;
         prev_rstall = rsp_valid && !rsp_ready;
         prev_rpa    = rsp_paddr;
         prev_rfault = rsp_fault;
      end
   end

   localparam logic [31:0] ROOT = 32'h0000_3000;

   function automatic logic [31:0] dir_ea(logic [31:0] va);
      return {ROOT[31:12], va[31:22], 2'b00};
   endfunction
   function automatic logic [31:0] tbl_ea(logic [31:0] ent, logic [31:0] va);
      return {ent[31:12], va[21:12], 2'b00};
   endfunction

   task automatic put(logic [31:0] addr, logic [31:0] val);
      @(negedge clk);
      mem[addr[13:2]] <= val;
   endtask

   // driver: one walk, then log and status checks
   task automatic walk(string req, logic [31:0] va, logic [1:0] kind, logic ef, logic elvl,
                       logic [31:0] epa, logic ewr, int nrd, int nwr,
                       logic [31:0] rd1, int stall);
      exp_t e;
      int rb, wb, d0;
      e.fault = ef; e.lvl = elvl; e.pa = epa; e.wr = ewr; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      stall_len = stall;
      rb = rd_total; wb = wr_total; d0 = done_cnt;
      req_vaddr = va; req_kind = kind; req_root = ROOT; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait (done_cnt == d0 + 1);
      @(negedge clk);
      chk(rd_total - rb == nrd, req, "read count", 32'(rd_total - rb), 32'(nrd));
      chk(wr_total - wb == nwr, req, "write-back count", 32'(wr_total - wb), 32'(nwr));
      chk(rd_log[rb % 16] == dir_ea(va), "R2", "first read address", rd_log[rb % 16], dir_ea(va));
      if (nrd == 2)
         chk(rd_log[(rb + 1) % 16] == rd1, "R3", "table read address", rd_log[(rb + 1) % 16], rd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_valid, "R1", "reset outputs",
          {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_valid, "R1", "idle after reset",
          {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);

      // page tables
      put(dir_ea(32'h0040_5123), 32'h0000_1003);
      put(32'h0000_1014, 32'hABCD_E003);
      put(32'h0000_1018, 32'h1234_5001);
      put(dir_ea(32'h0080_0000), 32'h0000_0000);
      put(dir_ea(32'h0C00_2000), 32'h0000_2023);
      put(32'h0000_2008, 32'h0000_0000);
      put(dir_ea(32'hFFC0_0ABC), 32'h0000_2021);
      put(32'h0000_2000, 32'hFEDC_B063);
      put(32'h0000_2FFC, 32'h0000_1003);
      put(dir_ea(32'h0100_0010), 32'h0000_0003);
      put(32'h0000_0000, 32'h5555_5003);

      // R4 R8: first read touch sets accessed at both levels
      walk("R4", 32'h0040_5123, 2'd0, 0, 0, 32'hABCD_E123, 1, 2, 2, 32'h0000_1014, 0);
      chk(mem[dir_ea(32'h0040_5123) >> 2] == 32'h0000_1023, "R8", "dir accessed set",
          mem[dir_ea(32'h0040_5123) >> 2], 32'h0000_1023);
      chk(mem[32'h1014 >> 2] == 32'hABCD_E023, "R8", "pte accessed set, not dirty",
          mem[32'h1014 >> 2], 32'hABCD_E023);
      // R9: write to clean page, with response stall
      walk("R9", 32'h0040_5123, 2'd1, 0, 0, 32'hABCD_E123, 1, 2, 1, 32'h0000_1014, 3);
      chk(mem[32'h1014 >> 2] == 32'hABCD_E063, "R9", "pte dirty set",
          mem[32'h1014 >> 2], 32'hABCD_E063);
      // R10: nothing left to update
      walk("R10", 32'h0040_5123, 2'd1, 0, 0, 32'hABCD_E123, 1, 2, 0, 32'h0000_1014, 0);
      // R7: fetch of read-only page succeeds, write faults at table level
      walk("R7", 32'h0040_6FFF, 2'd2, 0, 0, 32'h1234_5FFF, 0, 2, 1, 32'h0000_1018, 0);
      chk(mem[32'h1018 >> 2] == 32'h1234_5021, "R9", "fetch leaves dirty clear",
          mem[32'h1018 >> 2], 32'h1234_5021);
      walk("R7", 32'h0040_6FFF, 2'd1, 1, 1, 32'h0, 0, 2, 0, 32'h0000_1018, 0);
      chk(mem[32'h1018 >> 2] == 32'h1234_5021, "R10", "faulting pte untouched",
          mem[32'h1018 >> 2], 32'h1234_5021);
      // R5: absent directory entry
      walk("R5", 32'h0080_0000, 2'd0, 1, 0, 32'h0, 0, 1, 0, 32'h0, 0);
      // R6: absent table entry
      walk("R6", 32'h0C00_2000, 2'd0, 1, 1, 32'h0, 0, 2, 0, 32'h0000_2008, 2);
      // R7: write through read-only directory
      walk("R7", 32'hFFC0_0ABC, 2'd1, 1, 0, 32'h0, 0, 1, 0, 32'h0, 0);
      // R4: read through read-only directory, top directory index
      walk("R4", 32'hFFC0_0ABC, 2'd0, 0, 0, 32'hFEDC_BABC, 0, 2, 0, 32'h0000_2000, 0);
      walk("R4", 32'hFFFF_FFFF, 2'd0, 0, 0, 32'h0000_1FFF, 0, 2, 1, 32'h0000_2FFC, 2);
      chk(mem[32'h2FFC >> 2] == 32'h0000_1023, "R8", "top index pte accessed",
          mem[32'h2FFC >> 2], 32'h0000_1023);
      // R8 R9: write with both levels clean, dir write-back comes first
      walk("R9", 32'h0100_0010, 2'd1, 0, 0, 32'h5555_5010, 1, 2, 2, 32'h0000_0000, 0);
      chk(mem[dir_ea(32'h0100_0010) >> 2] == 32'h0000_0023, "R9", "dir gets accessed only",
          mem[dir_ea(32'h0100_0010) >> 2], 32'h0000_0023);
      chk(mem[0] == 32'h5555_5063, "R9", "pte accessed and dirty", mem[0], 32'h5555_5063);
      chk(wr_log[(wr_total - 2) % 16] == dir_ea(32'h0100_0010), "R8", "dir write-back first",
          wr_log[(wr_total - 2) % 16], dir_ea(32'h0100_0010));

      chk(hold_bad == 0, "R12", "memory request held while not ready", 32'(hold_bad), 32'd0);
      chk(range_bad == 0, "R2", "addresses inside table memory", 32'(range_bad), 32'd0);
      chk(exp_q.size() == 0, "R11", "all responses seen", 32'(exp_q.size()), 32'd0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         bad++;
         $display("FAIL watchdog run did not complete act=%h exp=%h", 32'd1, 32'd0);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule